// File: doc/BRIEF.md
# Per-Core Bus Interrupt Mailbox

This block gives every core one mailbox for interrupts that arrive from an external system bus. A request names a target core and carries a 5-bit source ID and two 64-bit payload words. When the target mailbox is free, the block accepts the request in the same cycle. It stores the payload, marks the mailbox busy and, one cycle later, posts a single shared, programmable 6-bit vector to that core. When the mailbox is occupied, the request is refused so that the sender can try again.

Cores use a simple register port to reach the mailboxes. They can address any mailbox through indexed windows, or their own mailbox through alias addresses that are resolved with the requester ID. A core frees its mailbox by writing zero into bit 5 of the busy register. The bus protocol that delivers the requests lies outside this block.

Top module: `bus_irq_mailbox`

## Requirements
- R1: A request with `irq_valid` high, `irq_core` below NUM_CORES, the target mailbox free and no busy-register write to that core in the same cycle raises `irq_ready` in that cycle. At the next clock edge the mailbox becomes busy and stores the source ID and both data words.
- R2: A request to a busy mailbox sees `irq_ready` low, and the mailbox contents stay unchanged.
- R3: On the clock edge after an accepted request, `post_valid` is high for one cycle. `post_core` then equals the accepted target core and `post_vec` equals the vector register value at acceptance.
- R4: A busy-register read returns the busy flag at bit 5 and the stored source ID at bits 4:0. All other bits read as zero.
- R5: A busy-register write loads the busy flag from bit 5 of `reg_wdata`: 0 releases the mailbox and 1 marks it busy. The stored source ID is kept.
- R6: A write to the vector register keeps bits 5:0 of `reg_wdata`. The register reads back zero-extended and its reset value is 0.
- R7: Addresses are byte addresses and bits 2:0 are ignored. With S = CORE_W+3, data word 0 of core c sits at (0<<S)+8c, data word 1 at (1<<S)+8c and busy status at (2<<S)+8c. The data windows are read-only.
- R8: The misc window at 3<<S holds the alias for data word 0 at +0x00, the alias for data word 1 at +0x08, the alias for busy at +0x10 and the vector register at +0x18. The alias entries access the mailbox of core `reg_req_id`.
- R9: If a busy-register write to core c and a request for core c occur in the same cycle, the write takes effect and the request is refused.
- R10: A request with `irq_core` at or above NUM_CORES is refused. Reads of slots at or above NUM_CORES, or of unmapped addresses, return 0, and writes to them change nothing.
- R11: After reset every mailbox is free with source 0 and zero data, the vector is 0 and `post_valid` is low.
- R12: `irq_ready` is low whenever `irq_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_valid | input | 1 | Incoming bus interrupt request |
| irq_core | input | CORE_W | Target core of the request |
| irq_src | input | 5 | Source ID of the request |
| irq_data0 | input | DATA_W | Payload word 0 |
| irq_data1 | input | DATA_W | Payload word 1 |
| irq_ready | output | 1 | Request accepted this cycle (low means retry) |
| post_valid | output | 1 | Vector posted to a core |
| post_core | output | CORE_W | Core receiving the posted vector |
| post_vec | output | 6 | Posted vector |
| reg_addr | input | CORE_W+5 | Register byte address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | DATA_W | Register write data |
| reg_req_id | input | CORE_W | ID of the requesting core, used by the alias entries |
| reg_rdata | output | DATA_W | Combinational register read data |

## Verification
The bench builds the block with NUM_CORES = 6, so CORE_W is 3. That leaves core codes 6 and 7 representable but unpopulated, so out-of-range requests and reads of unpopulated slots in the indexed windows can actually be driven. The smaller address space also places the misc window at 0xC0, where the alias entries and the vector register are reached with a handful of distinct requester IDs. The release-versus-request collision, self-set busy and a vector change between two posts are each driven as a directed case.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int SRC_W    = 5;
  localparam int VEC_W    = 6;
  localparam int BUSY_BIT = 5;
  localparam int STRIDE_SH = 3;

  typedef enum logic [2:0] {
    MK_NONE = 3'd0,
    MK_D0   = 3'd1,
    MK_D1   = 3'd2,
    MK_BUSY = 3'd3,
    MK_VEC  = 3'd4
  } mbx_kind_e;
endpackage

// File: rtl/mbx_regdec.sv
module mbx_regdec
  import mbx_pkg::*;
#(
  parameter int NUM_CORES = 32,
  parameter int CORE_W    = $clog2(NUM_CORES),
  parameter int ADDR_W    = CORE_W + 5
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [CORE_W-1:0] req_id,
  output mbx_kind_e         kind,
  output logic [CORE_W-1:0] slot,
  output logic              slot_ok
);
  localparam int WIN_SH = CORE_W + STRIDE_SH;

  logic [1:0]        win;
  logic [CORE_W-1:0] idx;

  function automatic logic in_range(input logic [CORE_W-1:0] c);
    return int'(c) < NUM_CORES;
  endfunction

  assign win = addr[ADDR_W-1:WIN_SH];
  assign idx = addr[WIN_SH-1:STRIDE_SH];

  always_comb begin
    kind = MK_NONE;
    slot = idx;
    unique case (win)
      2'd0: kind = MK_D0;
      2'd1: kind = MK_D1;
      2'd2: kind = MK_BUSY;
      default: begin
        slot = req_id;
        case (int'(idx))
          0:       kind = MK_D0;
          1:       kind = MK_D1;
          2:       kind = MK_BUSY;
          3:       kind = MK_VEC;
          default: kind = MK_NONE;
        endcase
      end
    endcase
  end

  assign slot_ok = in_range(slot);
endmodule

// File: rtl/mbx_slot.sv
module mbx_slot
  import mbx_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [SRC_W-1:0]  take_src,
  input  logic [DATA_W-1:0] take_d0,
  input  logic [DATA_W-1:0] take_d1,
  input  logic              busy_we,
  input  logic              busy_wval,
  output logic              busy_q,
  output logic [SRC_W-1:0]  src_q,
  output logic [DATA_W-1:0] d0_q,
  output logic [DATA_W-1:0] d1_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      src_q  <= '0;
      d0_q   <= '0;
      d1_q   <= '0;
    end else if (busy_we) begin
      busy_q <= busy_wval;
    end else if (take) begin
      busy_q <= 1'b1;
      src_q  <= take_src;
      d0_q   <= take_d0;
      d1_q   <= take_d1;
    end
  end
endmodule

// File: rtl/mbx_post.sv
module mbx_post
  import mbx_pkg::*;
#(
  parameter int CORE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [CORE_W-1:0] fire_core,
  input  logic [VEC_W-1:0]  fire_vec,
  output logic              post_valid,
  output logic [CORE_W-1:0] post_core,
  output logic [VEC_W-1:0]  post_vec
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      post_valid <= 1'b0;
      post_core  <= '0;
      post_vec   <= '0;
    end else begin
      post_valid <= fire;
      if (fire) begin
        post_core <= fire_core;
        post_vec  <= fire_vec;
      end
    end
  end
endmodule

// File: rtl/bus_irq_mailbox.sv
module bus_irq_mailbox
  import mbx_pkg::*;
#(
  parameter int NUM_CORES = 32,
  parameter int DATA_W    = 64,
  parameter int CORE_W    = $clog2(NUM_CORES),
  parameter int ADDR_W    = CORE_W + 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_valid,
  input  logic [CORE_W-1:0] irq_core,
  input  logic [SRC_W-1:0]  irq_src,
  input  logic [DATA_W-1:0] irq_data0,
  input  logic [DATA_W-1:0] irq_data1,
  output logic              irq_ready,
  output logic              post_valid,
  output logic [CORE_W-1:0] post_core,
  output logic [VEC_W-1:0]  post_vec,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [CORE_W-1:0] reg_req_id,
  output logic [DATA_W-1:0] reg_rdata
);
  logic [NUM_CORES-1:0] busy_q;
  logic [NUM_CORES-1:0] busy_we_vec;
  logic [NUM_CORES-1:0] accept_vec;
  logic [SRC_W-1:0]     src_q [NUM_CORES];
  logic [DATA_W-1:0]    d0_q  [NUM_CORES];
  logic [DATA_W-1:0]    d1_q  [NUM_CORES];
  logic [VEC_W-1:0]     vec_q;

  mbx_kind_e         kind;
  logic [CORE_W-1:0] slot;
  logic              slot_ok;
  logic              target_blocked;
  logic              target_ok;

  mbx_regdec #(
    .NUM_CORES(NUM_CORES),
    .CORE_W   (CORE_W),
    .ADDR_W   (ADDR_W)
  ) u_dec (
    .addr   (reg_addr),
    .req_id (reg_req_id),
    .kind   (kind),
    .slot   (slot),
    .slot_ok(slot_ok)
  );

  always_comb begin
    target_blocked = 1'b0;
    target_ok      = 1'b0;
    for (int c = 0; c < NUM_CORES; c++) begin
      if (irq_core == CORE_W'(c)) begin
        target_ok      = 1'b1;
        target_blocked = busy_q[c] | busy_we_vec[c];
      end
    end
  end

  assign irq_ready = irq_valid & target_ok & ~target_blocked;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_slot
    assign busy_we_vec[c] = reg_we & (kind == MK_BUSY) & slot_ok & (slot == CORE_W'(c));
    assign accept_vec[c]  = irq_ready & (irq_core == CORE_W'(c));

    mbx_slot #(.DATA_W(DATA_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (accept_vec[c]),
      .take_src (irq_src),
      .take_d0  (irq_data0),
      .take_d1  (irq_data1),
      .busy_we  (busy_we_vec[c]),
      .busy_wval(reg_wdata[BUSY_BIT]),
      .busy_q   (busy_q[c]),
      .src_q    (src_q[c]),
      .d0_q     (d0_q[c]),
      .d1_q     (d1_q[c])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      vec_q <= '0;
    else if (reg_we && kind == MK_VEC)
      vec_q <= reg_wdata[VEC_W-1:0];
  end

  mbx_post #(.CORE_W(CORE_W)) u_post (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (irq_ready),
    .fire_core (irq_core),
    .fire_vec  (vec_q),
    .post_valid(post_valid),
    .post_core (post_core),
    .post_vec  (post_vec)
  );

  always_comb begin
    reg_rdata = '0;
    case (kind)
      MK_D0:   if (slot_ok) reg_rdata = d0_q[slot];
      MK_D1:   if (slot_ok) reg_rdata = d1_q[slot];
      MK_BUSY: if (slot_ok) begin
        reg_rdata[BUSY_BIT]    = busy_q[slot];
        reg_rdata[SRC_W-1:0]   = src_q[slot];
      end
      MK_VEC:  reg_rdata[VEC_W-1:0] = vec_q;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/mbx_chk.sv
module mbx_chk
  import mbx_pkg::*;
#(
  parameter int NUM_CORES = 32,
  parameter int CORE_W    = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 irq_valid,
  input logic [CORE_W-1:0]    irq_core,
  input logic                 irq_ready,
  input logic                 post_valid,
  input logic [CORE_W-1:0]    post_core,
  input logic [VEC_W-1:0]     post_vec,
  input logic [NUM_CORES-1:0] busy_q,
  input logic [NUM_CORES-1:0] busy_we_vec,
  input logic [NUM_CORES-1:0] accept_vec,
  input logic [VEC_W-1:0]     vec_q
);
  function automatic logic bit_at(input logic [NUM_CORES-1:0] v, input logic [CORE_W-1:0] c);
    logic r;
    r = 1'b0;
    for (int i = 0; i < NUM_CORES; i++)
      if (c == CORE_W'(i)) r = v[i];
    return r;
  endfunction

  // R12
  ready_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_valid |-> !irq_ready);

  // R2
  refuse_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && bit_at(busy_q, irq_core)) |-> !irq_ready);

  // R9
  release_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && bit_at(busy_we_vec, irq_core)) |-> !irq_ready);

  // R10
  core_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(irq_core) >= NUM_CORES) |-> !irq_ready);

  // R1
  accept_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ready |=> bit_at(busy_q, $past(irq_core)));

  // R1
  accept_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(accept_vec));

  // R3
  post_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ready |=> (post_valid && post_core == $past(irq_core) && post_vec == $past(vec_q)));

  // R3
  post_only_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_ready |=> !post_valid);
endmodule

bind bus_irq_mailbox mbx_chk #(
  .NUM_CORES(NUM_CORES),
  .CORE_W   (CORE_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq_valid  (irq_valid),
  .irq_core   (irq_core),
  .irq_ready  (irq_ready),
  .post_valid (post_valid),
  .post_core  (post_core),
  .post_vec   (post_vec),
  .busy_q     (busy_q),
  .busy_we_vec(busy_we_vec),
  .accept_vec (accept_vec),
  .vec_q      (vec_q)
);

// File: tb/bus_irq_mailbox_tb_top.sv
module bus_irq_mailbox_tb_top;
  localparam int NC     = 6;
  localparam int CW     = 3;
  localparam int AW     = CW + 5;
  localparam int DW     = 64;
  localparam logic [AW-1:0] B_D0  = 8'h00;
  localparam logic [AW-1:0] B_D1  = 8'h40;
  localparam logic [AW-1:0] B_BSY = 8'h80;
  localparam logic [AW-1:0] A_D0  = 8'hC0;
  localparam logic [AW-1:0] A_D1  = 8'hC8;
  localparam logic [AW-1:0] A_BSY = 8'hD0;
  localparam logic [AW-1:0] A_VEC = 8'hD8;

  typedef struct packed {
    logic [CW-1:0] core;
    logic [4:0]    src;
    logic [63:0]   d0;
    logic [63:0]   d1;
    logic          exp_ok;
  } vec_t;

  localparam vec_t TBL [6] = '{
    '{3'd0, 5'd3,  64'hA5A5_0000_0000_0001, 64'h0F0F_0000_0000_0002, 1'b1},
    '{3'd5, 5'd31, 64'hDEAD_BEEF_0000_0005, 64'h1234_5678_9ABC_DEF0, 1'b1},
    '{3'd0, 5'd9,  64'hFFFF_FFFF_FFFF_FFFF, 64'hEEEE_EEEE_EEEE_EEEE, 1'b0},
    '{3'd6, 5'd1,  64'h1111_1111_1111_1111, 64'h2222_2222_2222_2222, 1'b0},
    '{3'd7, 5'd2,  64'h3333_3333_3333_3333, 64'h4444_4444_4444_4444, 1'b0},
    '{3'd2, 5'd0,  64'h0000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b1}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          irq_valid = 1'b0;
  logic [CW-1:0] irq_core = '0;
  logic [4:0]    irq_src = '0;
  logic [DW-1:0] irq_data0 = '0;
  logic [DW-1:0] irq_data1 = '0;
  logic          irq_ready;
  logic          post_valid;
  logic [CW-1:0] post_core;
  logic [5:0]    post_vec;
  logic [AW-1:0] reg_addr = '0;
  logic          reg_we = 1'b0;
  logic [DW-1:0] reg_wdata = '0;
  logic [CW-1:0] reg_req_id = '0;
  logic [DW-1:0] reg_rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bus_irq_mailbox #(.NUM_CORES(NC), .DATA_W(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .irq_valid(irq_valid), .irq_core(irq_core), .irq_src(irq_src),
    .irq_data0(irq_data0), .irq_data1(irq_data1), .irq_ready(irq_ready),
    .post_valid(post_valid), .post_core(post_core), .post_vec(post_vec),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_req_id(reg_req_id), .reg_rdata(reg_rdata)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [63:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic req(input logic [CW-1:0] c, input logic [4:0] s,
                     input logic [63:0] a, input logic [63:0] b,
                     input logic exp_ok, input logic [5:0] vec, input string tag);
    @(negedge clk);
    irq_valid = 1'b1; irq_core = c; irq_src = s; irq_data0 = a; irq_data1 = b;
    #1 check({tag, " ready"}, 64'(irq_ready), 64'(exp_ok));
    @(negedge clk);
    irq_valid = 1'b0;
    #1 check("R3 post_valid", 64'(post_valid), 64'(exp_ok));
    if (exp_ok) begin
      check("R3 post_core", 64'(post_core), 64'(c));
      check("R3 post_vec", 64'(post_vec), 64'(vec));
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [63:0] v;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R11 reset state, R12 ready low without valid
    #1 check("R11 post_valid", 64'(post_valid), 64'h0);
    check("R12 ready idle", 64'(irq_ready), 64'h0);
    rd(A_VEC, v);            check("R11 vec", v, 64'h0);
    rd(B_BSY + 8'h28, v);    check("R11 busy core5", v, 64'h0);
    rd(B_D0 + 8'h10, v);     check("R11 d0 core2", v, 64'h0);

    // R6 vector keeps bits 5:0
    wr(A_VEC, 64'hFFAA);
    rd(A_VEC, v);            check("R6 vec readback", v, 64'h2A);

    // table walk: R1, R2, R10
    for (int e = 0; e < 6; e++) begin
      req(TBL[e].core, TBL[e].src, TBL[e].d0, TBL[e].d1, TBL[e].exp_ok, 6'h2A,
          TBL[e].exp_ok ? "R1" : "R2/R10");
      if (TBL[e].exp_ok) begin
        rd(B_BSY + 8'(TBL[e].core) * 8, v);
        check("R4 busy fmt", v, 64'h20 | 64'(TBL[e].src));
        rd(B_D0 + 8'(TBL[e].core) * 8, v);  check("R7 d0 window", v, TBL[e].d0);
        rd(B_D1 + 8'(TBL[e].core) * 8, v);  check("R7 d1 window", v, TBL[e].d1);
      end
    end

    // R2 refused request stored nothing
    rd(B_D0, v);             check("R2 d0 kept", v, 64'hA5A5_0000_0000_0001);
    rd(B_BSY, v);            check("R2 src kept", v, 64'h23);

    // R8 alias entries follow reg_req_id
    reg_req_id = 3'd5;
    rd(A_D0, v);             check("R8 alias d0", v, 64'hDEAD_BEEF_0000_0005);
    rd(A_D1, v);             check("R8 alias d1", v, 64'h1234_5678_9ABC_DEF0);
    rd(A_BSY, v);            check("R8 alias busy", v, 64'h3F);

    // R10 unpopulated slot reads zero, writes ignored
    rd(B_D0 + 8'h30, v);     check("R10 slot6 d0", v, 64'h0);
    wr(B_BSY + 8'h38, 64'h20);
    rd(B_BSY + 8'h38, v);    check("R10 slot7 busy", v, 64'h0);

    // R7 data window is read-only
    wr(B_D0 + 8'h28, 64'h0BAD);
    rd(B_D0 + 8'h28, v);     check("R7 d0 read-only", v, 64'hDEAD_BEEF_0000_0005);

    // R5 release via indexed write keeps source
    wr(B_BSY, 64'h0);
    rd(B_BSY, v);            check("R5 release core0", v, 64'h03);
    req(3'd0, 5'd4, 64'h77, 64'h88, 1'b1, 6'h2A, "R1 after release");
    rd(B_BSY, v);            check("R4 core0 reacquired", v, 64'h24);

    // R5/R8 release via alias
    wr(A_BSY, 64'hFFFF_FFFF_FFFF_FFDF);
    rd(B_BSY + 8'h28, v);    check("R5 alias release", v, 64'h1F);

    // R5 writing 1 marks busy, then requests are refused
    wr(B_BSY + 8'h18, 64'h20);
    rd(B_BSY + 8'h18, v);    check("R5 set busy", v, 64'h20);
    req(3'd3, 5'd7, 64'h1, 64'h2, 1'b0, 6'h2A, "R2 self-set busy");

    // R9 release and request collide on core2
    @(negedge clk);
    reg_addr = B_BSY + 8'h10; reg_wdata = 64'h0; reg_we = 1'b1;
    irq_valid = 1'b1; irq_core = 3'd2; irq_src = 5'd12;
    irq_data0 = 64'h5; irq_data1 = 64'h6;
    #1 check("R9 collide ready", 64'(irq_ready), 64'h0);
    @(negedge clk);
    reg_we = 1'b0; irq_valid = 1'b0;
    #1 check("R9 no post", 64'(post_valid), 64'h0);
    rd(B_BSY + 8'h10, v);    check("R9 release applied", v, 64'h00);
    req(3'd2, 5'd12, 64'h5, 64'h6, 1'b1, 6'h2A, "R9 retry");

    // R3/R6 new vector used by next post
    wr(A_VEC, 64'h15);
    req(3'd1, 5'd16, 64'h9, 64'hA, 1'b1, 6'h15, "R1 core1");
    @(negedge clk);
    #1 check("R3 single pulse", 64'(post_valid), 64'h0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule